// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block is the bus-master side of a processor's vector fetch for maskable interrupts. When it sees an interrupt request while idle, it issues two special read cycles on a 64-bit data bus. The two cycles run back to back as a locked pair, and each one waits for the system's ready response. From the second cycle it takes an 8-bit vector off the lowest data byte and hands it to the core with a one-clock valid strobe.

During both cycles the cycle-type pins mark the transfer as a non-memory, non-code read, and the address is all zeros. The two cycles differ only in their byte-enable pattern. A configurable number of idle clocks (at least one) separates them. The lock output covers the whole pair, including that gap, so no other master can slip in between. Data returned on the first cycle, and on every byte lane except the lowest, is never used.

The reset input is asynchronous and active-low. Inside the block it is released in step with the clock. All control outputs are active-high.

Top module: `intack_sequencer`

## Requirements
- R1: When irq_req is sampled high in idle, addr_strobe is high for exactly one clock, in the following clock. A second one-clock addr_strobe opens the second cycle. addr_strobe is never high in two consecutive clocks.
- R2: While the block runs, data_code, mem_io and wr_rd are driven 0 (non-code, I/O-space, read) and bus_addr is all zeros.
- R3: byte_en_n is active-low, one bit per data byte, with bit 0 for bus_din[7:0]. It is 8'hEF from the first strobe clock through the clock in which that cycle's ready is sampled. It is 8'hFE over the same span of the second cycle. It is 8'hFF in every other clock.
- R4: After the first cycle's ready is sampled, exactly GAP_CLKS idle clocks follow (default 1), with no strobe and byte_en_n = 8'hFF. The second strobe then appears.
- R5: bus_lock is high continuously from the first strobe clock through the clock in which the second cycle's ready is sampled, including the gap. It is low in every other clock.
- R6: A cycle ends only on a clock after its strobe clock in which bus_rdy is high. bus_rdy in the strobe clock, in the gap and in idle is ignored. Any number of wait clocks is allowed.
- R7: vec_out takes bus_din[7:0] as sampled with the second cycle's ready. Data from the first cycle and bus_din[63:8] never affect it.
- R8: vec_valid is high for exactly one clock, the clock after the second ready, with bus_lock already low. vec_out holds its value until the next capture.
- R9: irq_req is ignored from the first strobe through the vec_valid clock. A request held over that span does not start a new pair afterwards. A request raised in idle again is accepted.
- R10: While rst_n is low, the block is idle at once: addr_strobe, bus_lock and vec_valid are 0, byte_en_n is 8'hFF and vec_out is 0. After rst_n rises, a request is accepted no earlier than the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending maskable interrupt accepted by the core |
| bus_rdy | input | 1 | Ready from system logic, ends the current cycle |
| bus_din | input | 64 | Read data bus |
| addr_strobe | output | 1 | One-clock start-of-cycle strobe |
| bus_addr | output | 29 | Quadword address (address bits 31 down to 3) |
| byte_en_n | output | 8 | Active-low byte enables |
| data_code | output | 1 | Data/code cycle type, 0 during acknowledge |
| mem_io | output | 1 | Memory/I-O cycle type, 0 during acknowledge |
| wr_rd | output | 1 | Write/read, 0 for read |
| bus_lock | output | 1 | Bus lock held across the cycle pair |
| vec_valid | output | 1 | One-clock strobe: vector captured |
| vec_out | output | 8 | Captured interrupt vector |

## Verification
The bench raises bus_rdy in each strobe clock and in the gap. A design that ended a cycle early, or shortened the gap, would shift its byte-enable pattern and strobe timing away from the expected ones. Each first cycle returns a different low byte, and each second cycle returns random upper bytes. A design that latched the wrong cycle or lane would show a wrong vec_out. The bench holds irq_req high across whole pairs and then checks that idle lasts; a design that queued the request would restart on its own. A reset in the middle of a pair must drop bus_lock at once, or the bus would stay held.

// File: rtl/intack_pkg.sv
package intack_pkg;

  // Sequencer states: one acknowledge pair walks these in order.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_C1_ADR  = 3'd1,
    ST_C1_WAIT = 3'd2,
    ST_GAP     = 3'd3,
    ST_C2_ADR  = 3'd4,
    ST_C2_WAIT = 3'd5,
    ST_DONE    = 3'd6
  } ack_state_e;

  // Which of the two cycles is on the bus (drives the byte-enable code).
  typedef enum logic [1:0] {
    CYC_NONE   = 2'd0,
    CYC_FIRST  = 2'd1,
    CYC_SECOND = 2'd2
  } ack_cycle_e;

endpackage

// File: rtl/intack_rst_sync.sv
module intack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/intack_gap_timer.sv
module intack_gap_timer #(
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int CNT_W = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  // Clear wins over count; counter idles otherwise.
  always_comb begin
    cnt_ce = clr | en;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && (cnt_q != LAST)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = en && (cnt_q == LAST);

  // R4: the counter never runs past the programmed gap length.
  a_r4_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= LAST));

  // R4: the gap is not cut short: while counting and not finished, it keeps counting.
  a_r4_gap_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !done) |=> en);

endmodule

// File: rtl/intack_vec_capture.sv
module intack_vec_capture #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [VEC_W-1:0] din_lo,
  output logic [VEC_W-1:0] vec
);

  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    vec_d = cap_en ? din_lo : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (cap_en) begin
      vec_q <= vec_d;
    end
  end

  assign vec = vec_q;

  // R7: a capture loads exactly the low data byte seen at the second ready.
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (vec_q == $past(din_lo)));

  // R8: outside a capture the vector holds.
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(vec_q));

endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int BE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            bus_rdy,
  input  logic            gap_done,
  output logic            gap_clr,
  output logic            gap_en,
  output logic            cap_en,
  output logic            addr_strobe,
  output logic            bus_lock,
  output logic [BE_W-1:0] byte_en_n,
  output logic            vec_valid
);

  // First cycle enables the lane at the middle of the bus, the second only lane 0.
  localparam logic [BE_W-1:0] BE_N_FIRST  = ~(BE_W'(1) << (BE_W / 2));
  localparam logic [BE_W-1:0] BE_N_SECOND = ~BE_W'(1);
  localparam logic [BE_W-1:0] BE_N_NONE   = '1;

  ack_state_e st_q;
  ack_state_e st_d;
  ack_cycle_e cyc;

  // Next-state process.
  always_comb begin
    st_d    = st_q;
    gap_clr = 1'b0;
    gap_en  = 1'b0;
    cap_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (irq_req) st_d = ST_C1_ADR;
      end
      ST_C1_ADR: begin
        st_d = ST_C1_WAIT;
      end
      ST_C1_WAIT: begin
        if (bus_rdy) begin
          st_d    = ST_GAP;
          gap_clr = 1'b1;
        end
      end
      ST_GAP: begin
        gap_en = 1'b1;
        if (gap_done) st_d = ST_C2_ADR;
      end
      ST_C2_ADR: begin
        st_d = ST_C2_WAIT;
      end
      ST_C2_WAIT: begin
        if (bus_rdy) begin
          st_d   = ST_DONE;
          cap_en = 1'b1;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // Output decode (Moore): every bus pin is a function of the state alone.
  always_comb begin
    addr_strobe = 1'b0;
    bus_lock    = 1'b0;
    vec_valid   = 1'b0;
    cyc         = CYC_NONE;
    unique case (st_q)
      ST_C1_ADR: begin
        addr_strobe = 1'b1;
        bus_lock    = 1'b1;
        cyc         = CYC_FIRST;
      end
      ST_C1_WAIT: begin
        bus_lock = 1'b1;
        cyc      = CYC_FIRST;
      end
      ST_GAP: begin
        bus_lock = 1'b1;
      end
      ST_C2_ADR: begin
        addr_strobe = 1'b1;
        bus_lock    = 1'b1;
        cyc         = CYC_SECOND;
      end
      ST_C2_WAIT: begin
        bus_lock = 1'b1;
        cyc      = CYC_SECOND;
      end
      ST_DONE: begin
        vec_valid = 1'b1;
      end
      default: begin
        cyc = CYC_NONE;
      end
    endcase
  end

  always_comb begin
    unique case (cyc)
      CYC_FIRST:  byte_en_n = BE_N_FIRST;
      CYC_SECOND: byte_en_n = BE_N_SECOND;
      default:    byte_en_n = BE_N_NONE;
    endcase
  end

  // R1: a strobe never lasts more than one clock.
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);

  // R3: a strobe always carries one of the two acknowledge byte-enable codes.
  a_r3_strobe_be: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> ((byte_en_n == BE_N_FIRST) || (byte_en_n == BE_N_SECOND)));

  // R5: lock is up whenever a cycle starts.
  a_r5_lock_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> bus_lock);

  // R4: the clock after the first ready is an idle, still-locked clock.
  a_r4_idle_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_C1_WAIT && bus_rdy) |=> (!addr_strobe && bus_lock && byte_en_n == BE_N_NONE));

  // R8: the valid strobe is one clock wide and the lock is already released.
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (!bus_lock && !addr_strobe));
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R5: lock only falls when the pair completes.
  a_r5_lock_falls_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> vec_valid);

  // R9: after the valid strobe the block is idle, whatever irq_req does.
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> (!addr_strobe && !bus_lock));

endmodule

// File: rtl/intack_sequencer.sv
module intack_sequencer #(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 29,
  parameter int VEC_W    = 8,
  parameter int GAP_CLKS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_req,
  input  logic                bus_rdy,
  input  logic [DATA_W-1:0]   bus_din,
  output logic                addr_strobe,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] byte_en_n,
  output logic                data_code,
  output logic                mem_io,
  output logic                wr_rd,
  output logic                bus_lock,
  output logic                vec_valid,
  output logic [VEC_W-1:0]    vec_out
);

  localparam int BE_W = DATA_W / 8;

  logic rst_int_n;
  logic gap_clr;
  logic gap_en;
  logic gap_done;
  logic cap_en;
  logic unused_upper_data;

  intack_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  intack_ctrl #(
    .BE_W(BE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .irq_req    (irq_req),
    .bus_rdy    (bus_rdy),
    .gap_done   (gap_done),
    .gap_clr    (gap_clr),
    .gap_en     (gap_en),
    .cap_en     (cap_en),
    .addr_strobe(addr_strobe),
    .bus_lock   (bus_lock),
    .byte_en_n  (byte_en_n),
    .vec_valid  (vec_valid)
  );

  intack_gap_timer #(
    .GAP_CLKS(GAP_CLKS)
  ) u_gap (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (gap_clr),
    .en   (gap_en),
    .done (gap_done)
  );

  intack_vec_capture #(
    .VEC_W(VEC_W)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cap_en(cap_en),
    .din_lo(bus_din[VEC_W-1:0]),
    .vec   (vec_out)
  );

  // Only the lowest byte lane carries the vector; the rest is discarded.
  assign unused_upper_data = ^bus_din[DATA_W-1:VEC_W];

  // Acknowledge cycles: I/O-space, non-code, read, address zero.
  assign bus_addr  = '0;
  assign data_code = 1'b0;
  assign mem_io    = 1'b0;
  assign wr_rd     = 1'b0;

endmodule

// File: tb/tb_intack_sequencer.sv
`timescale 1ns/1ps
module tb_intack_sequencer;

  localparam int GAP = 1;

  logic        clk;
  logic        rst_n;
  logic        irq_req;
  logic        bus_rdy;
  logic [63:0] bus_din;
  logic        addr_strobe;
  logic [28:0] bus_addr;
  logic [7:0]  byte_en_n;
  logic        data_code;
  logic        mem_io;
  logic        wr_rd;
  logic        bus_lock;
  logic        vec_valid;
  logic [7:0]  vec_out;

  int n_chk;
  int n_fail;

  intack_sequencer #(.GAP_CLKS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_rdy(bus_rdy),
    .bus_din(bus_din), .addr_strobe(addr_strobe), .bus_addr(bus_addr),
    .byte_en_n(byte_en_n), .data_code(data_code), .mem_io(mem_io),
    .wr_rd(wr_rd), .bus_lock(bus_lock), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected byte-enable code: 0 idle, 1 first cycle, 2 second cycle (R3).
  function automatic logic [7:0] be_for(int cyc);
    case (cyc)
      1:       return 8'hEF;
      2:       return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] vec_of(logic [63:0] d);
    return d[7:0];
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(bit s, bit l, logic [7:0] be, bit v);
    chk("R1", 64'(addr_strobe), 64'(s), "addr_strobe");
    chk("R5", 64'(bus_lock), 64'(l), "bus_lock");
    chk("R3", 64'(byte_en_n), 64'(be), "byte_en_n");
    chk("R8", 64'(vec_valid), 64'(v), "vec_valid");
    chk("R2", 64'({data_code, mem_io, wr_rd}), 64'd0, "cycle type");
    chk("R2", 64'(bus_addr), 64'd0, "bus_addr");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One full acknowledge pair; noise holds irq_req high all the way through.
  task automatic run_ack(int w1, int w2, logic [63:0] d1, logic [63:0] d2, bit noise);
    expect_bus(0, 0, be_for(0), 0);
    irq_req = 1'b1;
    bus_rdy = 1'($urandom % 2);
    tick();
    // First strobe clock: ready here must be ignored (R6).
    expect_bus(1, 1, be_for(1), 0);
    irq_req = noise;
    bus_rdy = 1'b1;
    bus_din = d1;
    tick();
    for (int i = 0; i < w1; i++) begin
      expect_bus(0, 1, be_for(1), 0);
      chk("R6", 64'(byte_en_n), 64'(be_for(1)), "first cycle wait state");
      bus_rdy = 1'b0;
      bus_din = rnd64();
      tick();
    end
    expect_bus(0, 1, be_for(1), 0);
    bus_rdy = 1'b1;
    bus_din = d1;
    tick();
    for (int g = 0; g < GAP; g++) begin
      chk("R4", 64'(addr_strobe), 64'd0, "idle gap strobe");
      expect_bus(0, 1, be_for(0), 0);
      bus_rdy = 1'($urandom % 2);
      bus_din = rnd64();
      tick();
    end
    chk("R4", 64'(addr_strobe), 64'd1, "second strobe after gap");
    expect_bus(1, 1, be_for(2), 0);
    bus_rdy = 1'b1;
    bus_din = rnd64();
    tick();
    for (int i = 0; i < w2; i++) begin
      expect_bus(0, 1, be_for(2), 0);
      chk("R6", 64'(vec_valid), 64'd0, "second cycle wait state");
      bus_rdy = 1'b0;
      bus_din = rnd64();
      tick();
    end
    expect_bus(0, 1, be_for(2), 0);
    bus_rdy = 1'b1;
    bus_din = d2;
    tick();
    expect_bus(0, 0, be_for(0), 1);
    chk("R7", 64'(vec_out), 64'(vec_of(d2)), "captured vector");
    bus_rdy = 1'b0;
    bus_din = rnd64();
    tick();
    expect_bus(0, 0, be_for(0), 0);
    chk("R8", 64'(vec_out), 64'(vec_of(d2)), "vector held");
    irq_req = 1'b0;
    tick();
    if (noise) chk("R9", 64'(addr_strobe), 64'd0, "request held over pair not queued");
    expect_bus(0, 0, be_for(0), 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    irq_req = 1'b0;
    bus_rdy = 1'b0;
    bus_din = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10: reset state.
    chk("R10", 64'(addr_strobe), 64'd0, "reset strobe");
    chk("R10", 64'(bus_lock), 64'd0, "reset lock");
    chk("R10", 64'(vec_valid), 64'd0, "reset valid");
    chk("R10", 64'(byte_en_n), 64'hFF, "reset byte enables");
    chk("R10", 64'(vec_out), 64'd0, "reset vector");
    rst_n = 1'b1;
    irq_req = 1'b1;
    tick();
    chk("R10", 64'(addr_strobe), 64'd0, "request during reset release");
    irq_req = 1'b0;
    repeat (2) tick();

    // Directed: no wait states, first-cycle data with a distinct low byte.
    run_ack(0, 0, 64'h0123_4567_89AB_CD5A, 64'hFFFF_FFFF_FFFF_FF00, 1'b0);
    // Directed: long waits, request held through the pair.
    run_ack(5, 9, 64'hDEAD_BEEF_0000_00C3, 64'h1111_2222_3333_4481, 1'b1);
    // Directed: back-to-back, R9 acceptance right after a pair.
    run_ack(1, 0, 64'h0, 64'h0000_0000_0000_00FF, 1'b0);

    // Reset in the middle of a pair drops the lock at once (R10).
    irq_req = 1'b1;
    tick();
    irq_req = 1'b0;
    bus_rdy = 1'b1;
    tick();
    tick();
    chk("R5", 64'(bus_lock), 64'd1, "lock in gap before reset");
    rst_n = 1'b0;
    #1;
    chk("R10", 64'(bus_lock), 64'd0, "lock after mid-pair reset");
    chk("R10", 64'(addr_strobe), 64'd0, "strobe after mid-pair reset");
    chk("R10", 64'(byte_en_n), 64'hFF, "byte enables after mid-pair reset");
    chk("R10", 64'(vec_out), 64'd0, "vector after mid-pair reset");
    bus_rdy = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // Random pairs.
    for (int n = 0; n < 300; n++) begin
      run_ack(int'($urandom % 8), int'($urandom % 8), rnd64(), rnd64(), 1'($urandom % 2));
      repeat (int'($urandom % 3)) tick();
    end

    summary();
    $finish;
  end

endmodule